// File: doc/BRIEF.md
# Paged Address Translator with Register Page Table

This block maps a 16-bit logical address onto a 17-bit physical address. It splits the address into a page index and an in-page offset, looks the index up in a small page table, and builds the physical address from the stored frame number and the untouched offset. The table sits entirely in flip-flops, so a lookup never has to read memory.

The table has eight entries. Each entry holds a 4-bit frame number and a valid bit. Software fills or refills the table through a single write port, one entry per cycle. On a context switch it rewrites all eight entries with the incoming process's mapping. A caller raises `req_valid` with a logical address. One cycle later the block answers with a response strobe, the physical address, and either an "address usable" flag or a fault flag.

Top module: `paged_xlate_top`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `rsp_fault`, `rsp_paddr_ok` and `rsp_paddr` are all 0, and every table entry is invalid, so any translation faults until its entry is written.
- R2: Bits [12:0] of `rsp_paddr` equal bits [12:0] of the logical address that was requested, whenever the entry is valid.
- R3: Bits [15:13] of the logical address select the table entry. Bits [16:13] of `rsp_paddr` carry that entry's 4-bit frame number.
- R4: With page 2 mapped to frame 11, logical address 18325 translates to physical address 92053.
- R5: A request sampled at a clock edge produces `rsp_valid` = 1 at the next edge, carrying that request's result.
- R6: A translation through an invalid entry gives `rsp_fault` = 1, `rsp_paddr_ok` = 0 and `rsp_paddr` = 0. A valid entry gives `rsp_fault` = 0 and `rsp_paddr_ok` = 1.
- R7: A write with `wr_en` = 1 stores `wr_frame` and `wr_valid` into entry `wr_page`. A write with `wr_valid` = 0 invalidates that entry.
- R8: A write and a translation of the same page in the same cycle: the translation uses the old entry, and the new entry applies from the next cycle on.
- R9: Rewriting all eight entries (a context switch) fully replaces the previous mapping for every page.
- R10: In a cycle after one with no request, `rsp_valid`, `rsp_fault` and `rsp_paddr_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 3 | Entry to write |
| wr_frame | input | 4 | Frame number to store |
| wr_valid | input | 1 | Valid bit to store |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 16 | Logical address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_paddr | output | 17 | Physical address (0 on fault) |
| rsp_paddr_ok | output | 1 | Physical address is usable |
| rsp_fault | output | 1 | Entry was invalid |

## Verification
The bench sweeps every page against every frame number, using offsets at zero, at the all-ones limit and in mixed patterns. A design that swapped the split point or shifted the frame by one bit would corrupt the high or low field, and a design that indexed the wrong entry would return a neighbour's frame. The bench then issues a write and a translation to one page in the same cycle. A design that bypassed the new value into the lookup would answer with the new frame instead of the old one. It also invalidates an entry, checks the reset state and reloads the full table. A design that dropped the valid bit, kept a stale mapping, or left `rsp_paddr` nonzero on a fault would be caught.

// File: rtl/xlate_pkg.sv
// Shared defaults for the paged translator: address and frame geometry.
// Assumes power-of-two page size; the offset width is derived by users.
package xlate_pkg;
    localparam int DEF_LA_W    = 16;  // logical address width
    localparam int DEF_PG_W    = 3;   // page index width (eight pages)
    localparam int DEF_FRAME_W = 4;   // frame number width (sixteen frames)
endpackage

// File: rtl/xlate_table.sv
// Register page table: one frame number and valid bit per page.
// Assumes one write per cycle; reads are combinational and see the
// value held before any write landing at the coming edge.
module xlate_table #(
    parameter int PG_W    = 3,
    parameter int FRAME_W = 4,
    localparam int PAGES  = 1 << PG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PG_W-1:0]    wr_page,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [PG_W-1:0]    rd_page,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid
);
    logic [FRAME_W-1:0] frame_q [PAGES];
    logic               valid_q [PAGES];

    for (genvar g = 0; g < PAGES; g++) begin : g_entry
        // Store or clear one entry on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[g] <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_page == PG_W'(g))) begin
                frame_q[g] <= wr_frame;
                valid_q[g] <= wr_valid;
            end
        end

        // R7: a write to this entry is visible in the next cycle
        a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_page == PG_W'(g)) |=>
            (frame_q[g] == $past(wr_frame) && valid_q[g] == $past(wr_valid)));
    end

    // Read the selected entry.
    always_comb begin
        rd_frame = frame_q[rd_page];
        rd_valid = valid_q[rd_page];
    end
endmodule

// File: rtl/xlate_lookup.sv
// Combinational address split and compose: page index from the high
// bits, physical address = frame above the unchanged offset.
// Assumes LA_W > PG_W.
module xlate_lookup #(
    parameter int LA_W    = 16,
    parameter int PG_W    = 3,
    parameter int FRAME_W = 4,
    localparam int OFF_W  = LA_W - PG_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic [LA_W-1:0]    laddr,
    input  logic [FRAME_W-1:0] frame,
    input  logic               entry_valid,
    output logic [PG_W-1:0]    page,
    output logic [PA_W-1:0]    paddr,
    output logic               fault
);
    // Split the logical address and build the physical one.
    always_comb begin
        page  = laddr[LA_W-1:OFF_W];
        paddr = entry_valid ? {frame, laddr[OFF_W-1:0]} : '0;
        fault = !entry_valid;
    end
endmodule

// File: rtl/xlate_resp.sv
// Response register: captures the combinational result one cycle
// after a request and raises a one-cycle strobe.
// Assumes a request every cycle is allowed.
module xlate_resp #(
    parameter int PA_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [PA_W-1:0] nxt_paddr,
    input  logic            nxt_fault,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_paddr_ok,
    output logic            rsp_fault
);
    // Register the result of a request; quiet the flags otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_paddr_ok <= 1'b0;
            rsp_fault    <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_paddr_ok <= req_valid && !nxt_fault;
            rsp_fault    <= req_valid && nxt_fault;
            if (req_valid) rsp_paddr <= nxt_paddr;
        end
    end

    // R6: fault and usable are never raised together
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fault && rsp_paddr_ok));
    // R10: no flag without a response strobe
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && !rsp_paddr_ok));
endmodule

// File: rtl/paged_xlate_top.sv
// Paged address translator top: register page table, combinational
// lookup, registered response one cycle after each request.
// Assumes writes and requests may coincide; lookups see the old entry.
module paged_xlate_top
    import xlate_pkg::*;
#(
    parameter int LA_W    = DEF_LA_W,
    parameter int PG_W    = DEF_PG_W,
    parameter int FRAME_W = DEF_FRAME_W,
    localparam int OFF_W  = LA_W - PG_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PG_W-1:0]    wr_page,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic               req_valid,
    input  logic [LA_W-1:0]    req_laddr,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_paddr_ok,
    output logic               rsp_fault
);
    logic [PG_W-1:0]    lk_page;
    logic [FRAME_W-1:0] lk_frame;
    logic               lk_valid;
    logic [PA_W-1:0]    lk_paddr;
    logic               lk_fault;

    xlate_table #(.PG_W(PG_W), .FRAME_W(FRAME_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_page(wr_page), .wr_frame(wr_frame), .wr_valid(wr_valid),
        .rd_page(lk_page), .rd_frame(lk_frame), .rd_valid(lk_valid)
    );

    xlate_lookup #(.LA_W(LA_W), .PG_W(PG_W), .FRAME_W(FRAME_W)) u_lookup (
        .laddr(req_laddr), .frame(lk_frame), .entry_valid(lk_valid),
        .page(lk_page), .paddr(lk_paddr), .fault(lk_fault)
    );

    xlate_resp #(.PA_W(PA_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .nxt_paddr(lk_paddr), .nxt_fault(lk_fault),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_paddr_ok(rsp_paddr_ok), .rsp_fault(rsp_fault)
    );

    // R5: every request is answered at the next edge
    a_r5_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2: offset passes through unchanged on a usable result
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_paddr_ok ||
                       rsp_paddr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0])));
    // R6: a faulted response carries a zero address
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));
endmodule

// File: tb/test_paged_xlate_top.sv
// Self-checking bench: exhaustive page x frame sweep plus corner cases.
module test_paged_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_page = '0;
    logic [3:0]  wr_frame = '0;
    logic        wr_valid = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_laddr = '0;
    logic        rsp_valid;
    logic [16:0] rsp_paddr;
    logic        rsp_paddr_ok;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    paged_xlate_top i_paged_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_page(wr_page), .wr_frame(wr_frame), .wr_valid(wr_valid),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_paddr_ok(rsp_paddr_ok), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_entry(input int page, input int frame, input bit vld);
        @(negedge clk);
        wr_en = 1'b1; wr_page = 3'(page); wr_frame = 4'(frame); wr_valid = vld;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Issue one request at a negedge; sample the response just after the edge.
    task automatic xlate(input logic [15:0] la);
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [15:0] la, input int frame);
        xlate(la);
        check({req, " rsp_valid"}, 32'(rsp_valid), 1);
        check({req, " ok"}, 32'(rsp_paddr_ok), 1);
        check({req, " fault"}, 32'(rsp_fault), 0);
        check({req, " paddr"}, 32'(rsp_paddr), frame * 8192 + (int'(la) % 8192));
    endtask

    task automatic expect_fault(input string req, input logic [15:0] la);
        xlate(la);
        check({req, " fault"}, 32'(rsp_fault), 1);
        check({req, " ok"}, 32'(rsp_paddr_ok), 0);
        check({req, " paddr zero"}, 32'(rsp_paddr), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 rsp_fault", 32'(rsp_fault), 0);
        check("R1 rsp_paddr_ok", 32'(rsp_paddr_ok), 0);
        check("R1 rsp_paddr", 32'(rsp_paddr), 0);
        @(negedge clk); rst_n = 1'b1;
        // R1: all entries invalid after reset
        for (int p = 0; p < 8; p++) expect_fault("R1", 16'(p * 8192 + 5));

        // R10: idle cycle drops strobe and flags
        @(posedge clk); #1;
        check("R10 rsp_valid", 32'(rsp_valid), 0);
        check("R10 fault", 32'(rsp_fault), 0);

        // R4: worked example
        write_entry(2, 11, 1'b1);
        xlate(16'd18325);
        check("R4 paddr", 32'(rsp_paddr), 92053);
        check("R4 ok", 32'(rsp_paddr_ok), 1);

        // R2 R3 R5: every page against every frame, three offsets
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 16; f++) begin
                write_entry(p, f, 1'b1);
                expect_ok("R3", 16'(p * 8192), f);
                expect_ok("R2", 16'(p * 8192 + 8191), f);
                expect_ok("R5", 16'(p * 8192 + ((p * 1237 + f * 311) % 8192)), f);
            end
        end

        // R7: invalidate one entry; neighbours unaffected
        for (int p = 0; p < 8; p++) write_entry(p, p + 3, 1'b1);
        write_entry(5, 9, 1'b0);
        expect_fault("R7", 16'(5 * 8192 + 100));
        expect_ok("R7 neighbour", 16'(4 * 8192 + 100), 7);
        expect_ok("R7 neighbour", 16'(6 * 8192 + 100), 9);

        // R8: same-cycle write and translate of page 3 (old frame 6)
        @(negedge clk);
        wr_en = 1'b1; wr_page = 3'd3; wr_frame = 4'd13; wr_valid = 1'b1;
        req_valid = 1'b1; req_laddr = 16'(3 * 8192 + 42);
        @(posedge clk); #1;
        wr_en = 1'b0; req_valid = 1'b0;
        check("R8 old entry used", 32'(rsp_paddr), 6 * 8192 + 42);
        expect_ok("R8 new entry next", 16'(3 * 8192 + 42), 13);
        // R8: same-cycle invalidation still uses old valid entry
        @(negedge clk);
        wr_en = 1'b1; wr_page = 3'd3; wr_frame = 4'd0; wr_valid = 1'b0;
        req_valid = 1'b1; req_laddr = 16'(3 * 8192 + 7);
        @(posedge clk); #1;
        wr_en = 1'b0; req_valid = 1'b0;
        check("R8 old valid used", 32'(rsp_paddr_ok), 1);
        expect_fault("R8 invalid next", 16'(3 * 8192 + 7));

        // R9: context switch reloads all entries
        for (int p = 0; p < 8; p++) write_entry(p, 15 - 2 * p, 1'b1);
        for (int p = 0; p < 8; p++) expect_ok("R9", 16'(p * 8192 + 999 + p), 15 - 2 * p);

        // R5 R10: back-to-back requests then idle
        @(negedge clk);
        req_valid = 1'b1; req_laddr = 16'(1 * 8192 + 1);
        @(posedge clk); #1;
        check("R5 b2b first", 32'(rsp_paddr), 13 * 8192 + 1);
        @(negedge clk); req_laddr = 16'(7 * 8192 + 2);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R5 b2b second", 32'(rsp_paddr), 1 * 8192 + 2);
        @(posedge clk); #1;
        check("R10 rsp_valid after", 32'(rsp_valid), 0);
        check("R10 ok after", 32'(rsp_paddr_ok), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule